// File: doc/BRIEF.md
# Thermal Event Domain Aggregator

This block gathers the threshold events of a set of on-die temperature sensors and turns them into three interrupt lines. Every sensor delivers three event flags: above the upper threshold, above the middle threshold, and below the lower threshold. The sensors are grouped into voltage domains. Each domain owns a sensor-select mask, and the selected sensors' flags are combined per event type into a 3-bit domain status.

The domain statuses then pass a second level of selection. Each event type has its own domain-enable mask. An enabled domain event sets a sticky raw status bit for that event type and domain. Software can also set or acknowledge these bits. Each interrupt line is the OR of the raw bits of its event type that are also enabled.

Every mask and raw bank is changed through separate write-one-to-set and write-one-to-clear strobes, so no read-modify-write is needed. Domain slots beyond the active count exist in the index space but hold nothing.

Top module: `thermal_evt_agg`

## Requirements
- R1: Each active domain has its own sensor mask, so a sensor can take part in one domain while another domain ignores it.
- R2: A domain-mask set strobe ORs the write data into the indexed mask, and a clear strobe removes the ones in the data. Zero bits leave the mask unchanged. The change is visible one cycle after the strobe. When both strobes occur in the same cycle, set bits win.
- R3: The domain status for the read index is combinational from the sensor inputs, with bit 0 = OR of below-lower flags, bit 1 = OR of above-middle flags and bit 2 = OR of above-upper flags, each taken over the selected sensors.
- R4: Domain indices at or above NUM_DOMAINS ignore writes and always read back a zero mask and a zero status.
- R5: Each event type has a domain-enable mask changed by set and clear strobes, with type code 0 = below-lower, 1 = above-middle and 2 = above-upper. Writes with type code 3 are ignored. The enable output bit t*NUM_DOMAINS+d belongs to type t and domain d.
- R6: A raw status bit sets one cycle after its domain event is high while its enable is set, and it can also be set by a software set strobe. It then stays set until it is cleared. Raw output bits use the same position as the enables.
- R7: A raw bit that is set by a hardware event or a software set in the same cycle as a clear stays set.
- R8: Interrupt line t is the OR of the raw bits of type t ANDed with the enables of type t, combinationally, so a raw bit whose enable is off does not raise the line.
- R9: After reset, all masks, enables and raw bits are zero and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sens_hot2_i | input | NUM_SENSORS | Per-sensor above-upper-threshold flags |
| sens_hot1_i | input | NUM_SENSORS | Per-sensor above-middle-threshold flags |
| sens_cold0_i | input | NUM_SENSORS | Per-sensor below-lower-threshold flags |
| dmask_set_we_i | input | 1 | Domain-mask set strobe |
| dmask_clr_we_i | input | 1 | Domain-mask clear strobe |
| dmask_idx_i | input | DIDX_W | Domain index for mask writes |
| dmask_wdata_i | input | NUM_SENSORS | Mask write data |
| rd_idx_i | input | DIDX_W | Domain index for read-back |
| rd_mask_o | output | NUM_SENSORS | Mask of the read domain |
| rd_stat_o | output | 3 | Combined status of the read domain |
| en_set_we_i | input | 1 | Enable set strobe |
| en_clr_we_i | input | 1 | Enable clear strobe |
| en_type_i | input | 2 | Event type for enable writes |
| en_wdata_i | input | NUM_DOMAINS | Enable write data, one bit per domain |
| raw_set_we_i | input | 1 | Raw status software set strobe |
| raw_clr_we_i | input | 1 | Raw status clear strobe |
| raw_type_i | input | 2 | Event type for raw writes |
| raw_wdata_i | input | NUM_DOMAINS | Raw write data, one bit per domain |
| en_o | output | 3*NUM_DOMAINS | All enable masks |
| raw_o | output | 3*NUM_DOMAINS | All raw status bits |
| irq_o | output | 3 | Interrupt lines, index = event type code |

## Verification
A single sensor flag is placed in overlapping and disjoint domain masks. This separates per-domain selection from a shared mask, and one event type from another. Enables are applied before and after an event, and software sets are made with the enable off. These cases separate sticky latching from level passing, and raw status from the masked interrupt. Set and clear strobes are applied in the same cycle to a mask and to a raw bit, and writes are aimed at the unused slot and the unused type code. A long run of random strobes, indices and sensor flags is then compared cycle by cycle with a behavioural model.

// File: rtl/tea_pkg.sv
package tea_pkg;
   localparam int EVT_TYPES = 3;
   localparam int EVT_W     = 2;

   typedef enum logic [EVT_W-1:0] {
      EVT_COLD0 = 2'd0,
      EVT_HOT1  = 2'd1,
      EVT_HOT2  = 2'd2
   } evt_type_e;
endpackage

// File: rtl/tea_w1_reg.sv
// Register bank with write-one-to-set and write-one-to-clear; set wins.
module tea_w1_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] set_mask_i,
   input  logic [WIDTH-1:0] clr_mask_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q_q;

   initial begin
      assert (WIDTH >= 1) else $fatal(1, "tea_w1_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= (q_q & ~clr_mask_i) | set_mask_i;
   end

   assign q_o = q_q;

   p_set_beats_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_mask_i) |=> ((q_o & $past(set_mask_i)) == $past(set_mask_i)));

   p_clear_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(clr_mask_i & ~set_mask_i)) |=> ((q_o & $past(clr_mask_i & ~set_mask_i)) == '0));

   p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((set_mask_i == '0) && (clr_mask_i == '0)) |=> $stable(q_o));
endmodule

// File: rtl/tea_domain.sv
// One voltage domain: sensor-select mask and per-type OR of selected flags.
module tea_domain
   import tea_pkg::*;
#(
   parameter int NUM_SENSORS = 6
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_SENSORS-1:0] set_mask_i,
   input  logic [NUM_SENSORS-1:0] clr_mask_i,
   input  logic [NUM_SENSORS-1:0] hot2_i,
   input  logic [NUM_SENSORS-1:0] hot1_i,
   input  logic [NUM_SENSORS-1:0] cold0_i,
   output logic [NUM_SENSORS-1:0] mask_o,
   output logic [EVT_TYPES-1:0]   stat_o
);
   logic [NUM_SENSORS-1:0] mask;

   tea_w1_reg #(.WIDTH(NUM_SENSORS)) u_mask (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_mask_i (set_mask_i),
      .clr_mask_i (clr_mask_i),
      .q_o        (mask)
   );

   always_comb begin
      stat_o            = '0;
      stat_o[EVT_COLD0] = |(cold0_i & mask);
      stat_o[EVT_HOT1]  = |(hot1_i  & mask);
      stat_o[EVT_HOT2]  = |(hot2_i  & mask);
   end

   assign mask_o = mask;

   p_masked_sensor_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((hot2_i | hot1_i | cold0_i) & mask_o) == '0) |-> (stat_o == '0));
endmodule

// File: rtl/tea_evt_bank.sv
// One event type: domain enables, sticky raw status and the interrupt line.
module tea_evt_bank #(
   parameter int NUM_DOMAINS = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_DOMAINS-1:0] dom_evt_i,
   input  logic [NUM_DOMAINS-1:0] en_set_i,
   input  logic [NUM_DOMAINS-1:0] en_clr_i,
   input  logic [NUM_DOMAINS-1:0] raw_sw_set_i,
   input  logic [NUM_DOMAINS-1:0] raw_clr_i,
   output logic [NUM_DOMAINS-1:0] en_o,
   output logic [NUM_DOMAINS-1:0] raw_o,
   output logic                   irq_o
);
   logic [NUM_DOMAINS-1:0] en_q;
   logic [NUM_DOMAINS-1:0] raw_q;
   logic [NUM_DOMAINS-1:0] raw_set;

   tea_w1_reg #(.WIDTH(NUM_DOMAINS)) u_en (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_mask_i (en_set_i),
      .clr_mask_i (en_clr_i),
      .q_o        (en_q)
   );

   assign raw_set = raw_sw_set_i | (dom_evt_i & en_q);

   tea_w1_reg #(.WIDTH(NUM_DOMAINS)) u_raw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_mask_i (raw_set),
      .clr_mask_i (raw_clr_i),
      .q_o        (raw_q)
   );

   assign en_o  = en_q;
   assign raw_o = raw_q;
   assign irq_o = |(raw_q & en_q);

   p_hw_event_latched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(dom_evt_i & en_o)) |=> ((raw_o & $past(dom_evt_i & en_o)) == $past(dom_evt_i & en_o)));

   p_irq_needs_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_o == '0) |-> !irq_o);

   p_irq_needs_raw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_o == '0) |-> !irq_o);
endmodule

// File: rtl/thermal_evt_agg.sv
module thermal_evt_agg
   import tea_pkg::*;
#(
   parameter int NUM_SENSORS = 6,
   parameter int NUM_DOMAINS = 3,
   parameter int DOM_SLOTS   = 4,
   localparam int DIDX_W     = (DOM_SLOTS > 1) ? $clog2(DOM_SLOTS) : 1,
   localparam int FLAT_W     = EVT_TYPES * NUM_DOMAINS
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_SENSORS-1:0] sens_hot2_i,
   input  logic [NUM_SENSORS-1:0] sens_hot1_i,
   input  logic [NUM_SENSORS-1:0] sens_cold0_i,
   input  logic                   dmask_set_we_i,
   input  logic                   dmask_clr_we_i,
   input  logic [DIDX_W-1:0]      dmask_idx_i,
   input  logic [NUM_SENSORS-1:0] dmask_wdata_i,
   input  logic [DIDX_W-1:0]      rd_idx_i,
   output logic [NUM_SENSORS-1:0] rd_mask_o,
   output logic [EVT_TYPES-1:0]   rd_stat_o,
   input  logic                   en_set_we_i,
   input  logic                   en_clr_we_i,
   input  logic [EVT_W-1:0]       en_type_i,
   input  logic [NUM_DOMAINS-1:0] en_wdata_i,
   input  logic                   raw_set_we_i,
   input  logic                   raw_clr_we_i,
   input  logic [EVT_W-1:0]       raw_type_i,
   input  logic [NUM_DOMAINS-1:0] raw_wdata_i,
   output logic [FLAT_W-1:0]      en_o,
   output logic [FLAT_W-1:0]      raw_o,
   output logic [EVT_TYPES-1:0]   irq_o
);
   initial begin
      assert (NUM_SENSORS >= 1) else $fatal(1, "thermal_evt_agg: need at least one sensor");
      assert (NUM_DOMAINS >= 1) else $fatal(1, "thermal_evt_agg: need at least one domain");
      assert (NUM_DOMAINS <= DOM_SLOTS) else $fatal(1, "thermal_evt_agg: more domains than slots");
   end

   logic [NUM_SENSORS-1:0] dmask [DOM_SLOTS];
   logic [EVT_TYPES-1:0]   dstat [DOM_SLOTS];

   // Domain slots: active ones hold a mask, the rest are tied off.
   for (genvar d = 0; d < DOM_SLOTS; d++) begin : g_slot
      if (d < NUM_DOMAINS) begin : g_active
         logic [NUM_SENSORS-1:0] set_m;
         logic [NUM_SENSORS-1:0] clr_m;
         logic                   hit;

         assign hit   = (dmask_idx_i == DIDX_W'(d));
         assign set_m = (dmask_set_we_i && hit) ? dmask_wdata_i : '0;
         assign clr_m = (dmask_clr_we_i && hit) ? dmask_wdata_i : '0;

         tea_domain #(.NUM_SENSORS(NUM_SENSORS)) u_dom (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .set_mask_i (set_m),
            .clr_mask_i (clr_m),
            .hot2_i     (sens_hot2_i),
            .hot1_i     (sens_hot1_i),
            .cold0_i    (sens_cold0_i),
            .mask_o     (dmask[d]),
            .stat_o     (dstat[d])
         );
      end else begin : g_unused
         assign dmask[d] = '0;
         assign dstat[d] = '0;
      end
   end

   always_comb begin
      rd_mask_o = '0;
      rd_stat_o = '0;
      if (int'(rd_idx_i) < DOM_SLOTS) begin
         rd_mask_o = dmask[rd_idx_i];
         rd_stat_o = dstat[rd_idx_i];
      end
   end

   // Event-type banks: gather one status bit per domain, then enable and latch.
   for (genvar t = 0; t < EVT_TYPES; t++) begin : g_type
      logic [NUM_DOMAINS-1:0] dom_evt;
      logic [NUM_DOMAINS-1:0] en_set;
      logic [NUM_DOMAINS-1:0] en_clr;
      logic [NUM_DOMAINS-1:0] raw_set;
      logic [NUM_DOMAINS-1:0] raw_clr;

      for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_gather
         assign dom_evt[d] = dstat[d][t];
      end

      assign en_set  = (en_set_we_i  && en_type_i  == EVT_W'(t)) ? en_wdata_i  : '0;
      assign en_clr  = (en_clr_we_i  && en_type_i  == EVT_W'(t)) ? en_wdata_i  : '0;
      assign raw_set = (raw_set_we_i && raw_type_i == EVT_W'(t)) ? raw_wdata_i : '0;
      assign raw_clr = (raw_clr_we_i && raw_type_i == EVT_W'(t)) ? raw_wdata_i : '0;

      tea_evt_bank #(.NUM_DOMAINS(NUM_DOMAINS)) u_bank (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .dom_evt_i    (dom_evt),
         .en_set_i     (en_set),
         .en_clr_i     (en_clr),
         .raw_sw_set_i (raw_set),
         .raw_clr_i    (raw_clr),
         .en_o         (en_o[t*NUM_DOMAINS +: NUM_DOMAINS]),
         .raw_o        (raw_o[t*NUM_DOMAINS +: NUM_DOMAINS]),
         .irq_o        (irq_o[t])
      );
   end

   p_unused_reads_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(rd_idx_i) >= NUM_DOMAINS) |-> ((rd_mask_o == '0) && (rd_stat_o == '0)));

   p_mask_write_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dmask_set_we_i && (int'(dmask_idx_i) < NUM_DOMAINS) && (rd_idx_i == dmask_idx_i))
      |=> (((rd_mask_o & $past(dmask_wdata_i)) == $past(dmask_wdata_i)) || (rd_idx_i != $past(rd_idx_i))));
endmodule

// File: tb/thermal_evt_agg_tb.sv
`timescale 1ns/1ps
module thermal_evt_agg_tb;
   localparam int NS = 6;
   localparam int ND = 3;
   localparam int SL = 4;
   localparam int IW = 2;
   localparam int FW = 3 * ND;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NS-1:0] hot2 = '0, hot1 = '0, cold0 = '0;
   logic          dm_set = 0, dm_clr = 0;
   logic [IW-1:0] dm_idx = '0, rd_idx = '0;
   logic [NS-1:0] dm_wd = '0;
   logic          en_set = 0, en_clr = 0, raw_set = 0, raw_clr = 0;
   logic [1:0]    en_ty = '0, raw_ty = '0;
   logic [ND-1:0] en_wd = '0, raw_wd = '0;
   logic [NS-1:0] rd_mask;
   logic [2:0]    rd_stat;
   logic [FW-1:0] en_o, raw_o;
   logic [2:0]    irq;

   thermal_evt_agg u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .sens_hot2_i(hot2), .sens_hot1_i(hot1), .sens_cold0_i(cold0),
      .dmask_set_we_i(dm_set), .dmask_clr_we_i(dm_clr), .dmask_idx_i(dm_idx),
      .dmask_wdata_i(dm_wd), .rd_idx_i(rd_idx), .rd_mask_o(rd_mask), .rd_stat_o(rd_stat),
      .en_set_we_i(en_set), .en_clr_we_i(en_clr), .en_type_i(en_ty), .en_wdata_i(en_wd),
      .raw_set_we_i(raw_set), .raw_clr_we_i(raw_clr), .raw_type_i(raw_ty), .raw_wdata_i(raw_wd),
      .en_o(en_o), .raw_o(raw_o), .irq_o(irq)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model.
   logic [NS-1:0] m_mask [SL];
   logic [ND-1:0] m_en [3];
   logic [ND-1:0] m_raw [3];

   function automatic logic [2:0] f_stat(input int d);
      logic [2:0] s;
      s = '0;
      if (d < ND) begin
         s[0] = |(cold0 & m_mask[d]);
         s[1] = |(hot1 & m_mask[d]);
         s[2] = |(hot2 & m_mask[d]);
      end
      return s;
   endfunction

   function automatic logic [FW-1:0] f_flat(input bit pick_raw);
      logic [FW-1:0] v;
      for (int t = 0; t < 3; t++)
         for (int d = 0; d < ND; d++)
            v[t*ND+d] = pick_raw ? m_raw[t][d] : m_en[t][d];
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < SL; d++) m_mask[d] = '0;
         for (int t = 0; t < 3; t++) begin m_en[t] = '0; m_raw[t] = '0; end
      end else begin
         logic [2:0] st [ND];
         for (int d = 0; d < ND; d++) st[d] = f_stat(d);
         for (int t = 0; t < 3; t++) begin
            logic [ND-1:0] hw, s, c;
            for (int d = 0; d < ND; d++) hw[d] = st[d][t] & m_en[t][d];
            s = (raw_set && raw_ty == 2'(t)) ? raw_wd : '0;
            c = (raw_clr && raw_ty == 2'(t)) ? raw_wd : '0;
            m_raw[t] = (m_raw[t] & ~c) | s | hw;
            s = (en_set && en_ty == 2'(t)) ? en_wd : '0;
            c = (en_clr && en_ty == 2'(t)) ? en_wd : '0;
            m_en[t] = (m_en[t] & ~c) | s;
         end
         if (int'(dm_idx) < ND) begin
            if (dm_clr) m_mask[dm_idx] = m_mask[dm_idx] & ~dm_wd;
            if (dm_set) m_mask[dm_idx] = m_mask[dm_idx] | dm_wd;
         end
      end
   end

   // Cycle-by-cycle comparison, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [2:0] ei;
         for (int t = 0; t < 3; t++) ei[t] = |(m_raw[t] & m_en[t]);
         chk(rd_mask == m_mask[rd_idx], "R2 model mask", 32'(rd_mask), 32'(m_mask[rd_idx]));
         chk(rd_stat == f_stat(int'(rd_idx)), "R3 model status", 32'(rd_stat), 32'(f_stat(int'(rd_idx))));
         chk(en_o == f_flat(0), "R5 model enables", 32'(en_o), 32'(f_flat(0)));
         chk(raw_o == f_flat(1), "R6 model raw", 32'(raw_o), 32'(f_flat(1)));
         chk(irq == ei, "R8 model irq", 32'(irq), 32'(ei));
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic pulse_dm(input bit s, input bit c, input int idx, input logic [NS-1:0] wd);
      tick(); dm_set = s; dm_clr = c; dm_idx = IW'(idx); dm_wd = wd;
      tick(); dm_set = 0; dm_clr = 0;
   endtask

   task automatic pulse_en(input bit s, input bit c, input int ty, input logic [ND-1:0] wd);
      tick(); en_set = s; en_clr = c; en_ty = 2'(ty); en_wd = wd;
      tick(); en_set = 0; en_clr = 0;
   endtask

   task automatic pulse_raw(input bit s, input bit c, input int ty, input logic [ND-1:0] wd);
      tick(); raw_set = s; raw_clr = c; raw_ty = 2'(ty); raw_wd = wd;
      tick(); raw_set = 0; raw_clr = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      @(negedge clk);
      chk(irq == 3'b000, "R9 reset irq", 32'(irq), 0);
      chk(raw_o == '0, "R9 reset raw", 32'(raw_o), 0);
      chk(en_o == '0, "R9 reset enables", 32'(en_o), 0);
      chk(rd_mask == '0, "R9 reset mask", 32'(rd_mask), 0);
      repeat (2) tick();
      rst_n = 1;

      pulse_dm(1, 0, 0, 6'b000011);
      pulse_dm(1, 0, 1, 6'b001100);
      pulse_dm(1, 0, 2, 6'b110001);
      tick(); hot2 = 6'b000001; rd_idx = 0;
      @(negedge clk);
      chk(rd_stat == 3'b100, "R1 sensor0 used in domain0", 32'(rd_stat), 32'h4);
      tick(); rd_idx = 1;
      @(negedge clk);
      chk(rd_stat == 3'b000, "R1 sensor0 ignored in domain1", 32'(rd_stat), 0);
      tick(); rd_idx = 2; cold0 = 6'b100000;
      @(negedge clk);
      chk(rd_stat == 3'b101, "R3 per-type OR domain2", 32'(rd_stat), 32'h5);
      chk(raw_o == '0, "R6 no latch without enable", 32'(raw_o), 0);
      tick(); cold0 = '0;

      pulse_en(1, 0, 2, 3'b001);
      @(negedge clk);
      chk(en_o == 9'h040, "R5 enable type2 domain0", 32'(en_o), 32'h40);
      tick(); hot2 = '0;
      @(negedge clk);
      chk(raw_o == 9'h040, "R6 event latched", 32'(raw_o), 32'h40);
      chk(irq == 3'b100, "R8 irq type2", 32'(irq), 32'h4);
      tick();
      @(negedge clk);
      chk(raw_o == 9'h040, "R6 sticky after event gone", 32'(raw_o), 32'h40);
      pulse_raw(0, 1, 2, 3'b001);
      @(negedge clk);
      chk(raw_o == '0 && irq == 3'b000, "R6 cleared by acknowledge", 32'(raw_o), 0);

      pulse_raw(1, 0, 1, 3'b100);
      @(negedge clk);
      chk(raw_o == 9'h020, "R6 software set", 32'(raw_o), 32'h20);
      chk(irq == 3'b000, "R8 raw without enable keeps irq low", 32'(irq), 0);
      pulse_en(1, 0, 1, 3'b100);
      @(negedge clk);
      chk(irq == 3'b010, "R8 irq type1 once enabled", 32'(irq), 32'h2);

      tick(); hot2 = 6'b000001;
      tick();
      pulse_raw(0, 1, 2, 3'b001);
      @(negedge clk);
      chk(raw_o[6] == 1'b1, "R7 hardware set beats clear", 32'(raw_o), 32'h60);
      pulse_raw(1, 1, 1, 3'b100);
      @(negedge clk);
      chk(raw_o[5] == 1'b1, "R7 software set beats clear", 32'(raw_o[5]), 1);
      tick(); hot2 = '0;

      pulse_dm(1, 1, 2, 6'b000110);
      tick(); rd_idx = 2;
      @(negedge clk);
      chk(rd_mask == 6'b110111, "R2 set and clear together", 32'(rd_mask), 32'h37);
      pulse_dm(0, 1, 2, 6'b100000);
      @(negedge clk);
      chk(rd_mask == 6'b010111, "R2 clear only", 32'(rd_mask), 32'h17);

      pulse_dm(1, 0, 3, 6'b111111);
      tick(); rd_idx = 3; hot2 = '1; hot1 = '1; cold0 = '1;
      @(negedge clk);
      chk(rd_mask == '0 && rd_stat == '0, "R4 unused slot stays empty", 32'({rd_mask, rd_stat}), 0);
      tick(); hot2 = '0; hot1 = '0; cold0 = '0;

      pulse_en(1, 0, 3, 3'b111);
      @(negedge clk);
      chk(en_o == 9'h060, "R5 type code 3 ignored", 32'(en_o), 32'h60);
      pulse_en(0, 1, 1, 3'b100);
      @(negedge clk);
      chk(en_o == 9'h040, "R5 enable clear", 32'(en_o), 32'h40);

      for (int i = 0; i < 3000; i++) begin
         tick();
         hot2 = NS'($urandom); hot1 = NS'($urandom); cold0 = NS'($urandom);
         dm_set = ($urandom % 4) == 0; dm_clr = ($urandom % 4) == 0;
         dm_idx = IW'($urandom); dm_wd = NS'($urandom); rd_idx = IW'($urandom);
         en_set = ($urandom % 3) == 0; en_clr = ($urandom % 3) == 0;
         en_ty = 2'($urandom); en_wd = ND'($urandom);
         raw_set = ($urandom % 5) == 0; raw_clr = ($urandom % 3) == 0;
         raw_ty = 2'($urandom); raw_wd = ND'($urandom);
      end
      tick();
      dm_set = 0; dm_clr = 0; en_set = 0; en_clr = 0; raw_set = 0; raw_clr = 0;
      repeat (3) tick();
      @(negedge clk);
      finish_run();
   end
endmodule